// File: doc/BRIEF.md
# Interrupt Recognition and Vectoring Unit

This block decides when a small sequential processor core takes an external interrupt. It samples an interrupt pin once per instruction cycle. A request is latched only after the pin has been seen high and then low on two consecutive cycle samples. The latched request is acknowledged at an instruction boundary, and only if interrupts are enabled. Acknowledgement is held back while the decoder reports a chain of control-transfer instructions or a chain of address-load instructions.

On acknowledgement the unit pushes a stack word. The word holds the next sequential address and the core's pending-skip flag. The unit also presents the fixed vector that the core loads into its program counter, and it clears the interrupt enable. The same three-entry return stack serves the core's ordinary calls and returns. Its top entry is always visible, so a return restores both the address and the saved skip state.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `int_en`, `irq_pending` and `irq_ack` are 0 and every stack entry holds address 0 with skip flag 0.
- R2: The pin is sampled only on clocks where `cyc_stb` is 1. `irq_pending` rises only after the pin was sampled high and then sampled low on two successive strobes (MIN_LOW = 2). A single low sample followed by a high sample leaves it at 0.
- R3: `irq_pending` stays 1 until an acknowledgement and is 0 on the clock after one. Pin activity while a request is pending is absorbed, and a fresh high sample is needed before a new request can form.
- R4: `irq_ack` is 1 exactly when `cyc_stb`, `instr_done`, `int_en` and `irq_pending` are all 1 and no chain hold applies.
- R5: The chain hold applies when (`done_xfer` and `nxt_xfer`) or (`done_lbi` and `nxt_lbi`), so acknowledgement happens only after the last instruction of such a chain.
- R6: On acknowledgement the stack top becomes `pc_in + 1` (modulo 2^10) with skip flag equal to `skip_pend`. Older entries move down one place and the bottom entry is lost.
- R7: `vec_pc` always presents the interrupt vector 0x0FF, which the core loads when `irq_ack` is 1.
- R8: `ien_set` sets `int_en`. `ien_clr` or an acknowledgement clears it, and the clear wins over a simultaneous set.
- R9: Without acknowledgement, `push_req` stores `push_pc` with skip flag 0 on top, and push wins over `pop_req`. `pop_req` alone moves every entry up one place and leaves the bottom entry unchanged, so `stk_pc`/`stk_skip` return the saved address and skip status.
- R10: On an acknowledgement clock, the core's `push_req` and `pop_req` have no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-clock strobe per instruction cycle |
| irq_pin | input | 1 | Interrupt request pin (already synchronised) |
| ien_set | input | 1 | Enable-interrupt instruction executed |
| ien_clr | input | 1 | Disable-interrupt request |
| instr_done | input | 1 | Current instruction completes on this strobe |
| done_xfer | input | 1 | Completing instruction is a control transfer |
| done_lbi | input | 1 | Completing instruction is an address-register load |
| nxt_xfer | input | 1 | Following instruction is a control transfer |
| nxt_lbi | input | 1 | Following instruction is an address-register load |
| pc_in | input | 10 | Address of the completing instruction |
| skip_pend | input | 1 | Core's pending-skip status |
| push_req | input | 1 | Core call: push `push_pc` |
| push_pc | input | 10 | Return address for a core call |
| pop_req | input | 1 | Core return: pop the stack |
| irq_ack | output | 1 | Interrupt acknowledged this clock |
| vec_pc | output | 10 | Interrupt vector address |
| int_en | output | 1 | Interrupt enable state |
| irq_pending | output | 1 | Qualified request waiting |
| stk_pc | output | 10 | Address in the top stack entry |
| stk_skip | output | 1 | Skip flag in the top stack entry |

## Verification
A corrupted qualifier count or armed flag shows at `irq_pending` on the clock after the strobe that should, or should not, have completed the two-sample low. A stuck enable or a wrong chain decode shows on `irq_ack` in the very clock where the boundary is presented, since the acknowledge is combinational. Stack faults show at `stk_pc`/`stk_skip` one clock after a push. A fault in a lower entry stays hidden until enough pops bring it to the top, so the bench pops deep stacks and compares the top against its model on every clock.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  // Next sequential address, wrapped to the program-counter width.
  function automatic int unsigned seq_addr(input int unsigned pc, input int unsigned w);
    int unsigned mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (pc + 32'd1) & mask;
  endfunction

  // True when acknowledgement must wait for the end of an instruction chain.
  function automatic logic chain_blocks(input logic dx, input logic dl,
                                        input logic nx, input logic nl);
    return (dx & nx) | (dl & nl);
  endfunction

  // Saturating increment used by the low-level counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/irq_pulse_qual.sv
module irq_pulse_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic pin,
  input  logic ack,
  output logic pending,
  output logic qual_evt
);
  import irq_unit_pkg::*;

  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic             armed;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] low_nxt;

  always_comb begin
    low_nxt  = CNT_W'(sat_inc(32'(low_cnt), 32'(MIN_LOW)));
    qual_evt = stb && !pin && armed && !pending && (32'(low_nxt) >= 32'(MIN_LOW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_cnt <= '0;
      pending <= 1'b0;
    end else begin
      if (stb) begin
        if (pin) begin
          armed   <= 1'b1;
          low_cnt <= '0;
        end else if (pending || !armed) begin
          armed   <= 1'b0;
          low_cnt <= '0;
        end else if (qual_evt) begin
          armed   <= 1'b0;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_nxt;
        end
      end
      if (qual_evt) begin
        pending <= 1'b1;
      end else if (ack) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic done,
  input  logic dx,
  input  logic dl,
  input  logic nx,
  input  logic nl,
  input  logic pending,
  input  logic en_set,
  input  logic en_clr,
  output logic ack,
  output logic en,
  output logic hold
);
  import irq_unit_pkg::*;

  always_comb begin
    hold = chain_blocks(dx, dl, nx, nl);
    ack  = stb && done && en && pending && !hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (ack || en_clr) begin
      en <= 1'b0;
    end else if (en_set) begin
      en <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] top_word
);

  logic [WORD_W-1:0] ent [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [WORD_W-1:0] from_above;
      logic [WORD_W-1:0] from_below;
      if (gi == 0) begin : g_top
        assign from_above = push_word;
      end else begin : g_mid
        assign from_above = ent[gi-1];
      end
      if (gi == DEPTH - 1) begin : g_bot
        assign from_below = ent[gi];
      end else begin : g_up
        assign from_below = ent[gi+1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent[gi] <= '0;
        end else if (push) begin
          ent[gi] <= from_above;
        end else if (pop) begin
          ent[gi] <= from_below;
        end
      end
    end
  endgenerate

  assign top_word = ent[0];

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int          PC_W    = 10,
  parameter int          DEPTH   = 3,
  parameter int          MIN_LOW = 2,
  parameter logic [PC_W-1:0] VECTOR = 10'h0FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_stb,
  input  logic            irq_pin,
  input  logic            ien_set,
  input  logic            ien_clr,
  input  logic            instr_done,
  input  logic            done_xfer,
  input  logic            done_lbi,
  input  logic            nxt_xfer,
  input  logic            nxt_lbi,
  input  logic [PC_W-1:0] pc_in,
  input  logic            skip_pend,
  input  logic            push_req,
  input  logic [PC_W-1:0] push_pc,
  input  logic            pop_req,
  output logic            irq_ack,
  output logic [PC_W-1:0] vec_pc,
  output logic            int_en,
  output logic            irq_pending,
  output logic [PC_W-1:0] stk_pc,
  output logic            stk_skip
);
  import irq_unit_pkg::*;

  localparam int WORD_W = PC_W + 1;

  // Named internal events, observed by the checker.
  logic              qual_evt;
  logic              chain_hold;
  logic              push_any;
  logic              pop_eff;
  logic [PC_W-1:0]   ret_addr;
  logic [WORD_W-1:0] push_word;
  logic [WORD_W-1:0] top_word;

  irq_pulse_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cyc_stb),
    .pin      (irq_pin),
    .ack      (irq_ack),
    .pending  (irq_pending),
    .qual_evt (qual_evt)
  );

  irq_accept_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (cyc_stb),
    .done    (instr_done),
    .dx      (done_xfer),
    .dl      (done_lbi),
    .nx      (nxt_xfer),
    .nl      (nxt_lbi),
    .pending (irq_pending),
    .en_set  (ien_set),
    .en_clr  (ien_clr),
    .ack     (irq_ack),
    .en      (int_en),
    .hold    (chain_hold)
  );

  always_comb begin
    ret_addr  = PC_W'(seq_addr(32'(pc_in), 32'(PC_W)));
    push_any  = irq_ack || push_req;
    pop_eff   = pop_req && !push_any;
    push_word = irq_ack ? {skip_pend, ret_addr} : {1'b0, push_pc};
  end

  irq_ret_stack #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_any),
    .push_word (push_word),
    .pop       (pop_eff),
    .top_word  (top_word)
  );

  assign vec_pc   = VECTOR;
  assign stk_pc   = top_word[PC_W-1:0];
  assign stk_skip = top_word[PC_W];

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_stb,
  input logic            irq_pin,
  input logic            instr_done,
  input logic            done_xfer,
  input logic            done_lbi,
  input logic            nxt_xfer,
  input logic            nxt_lbi,
  input logic [PC_W-1:0] pc_in,
  input logic            skip_pend,
  input logic            push_req,
  input logic [PC_W-1:0] push_pc,
  input logic            irq_ack,
  input logic            int_en,
  input logic            irq_pending,
  input logic [PC_W-1:0] stk_pc,
  input logic            stk_skip,
  input logic            qual_evt,
  input logic            chain_hold
);

  p_rst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!int_en && !irq_pending));

  p_qual_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |-> (cyc_stb && !irq_pin));

  p_pend_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(qual_evt));

  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_ack) |=> irq_pending);

  p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_pending);

  p_ack_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (int_en && irq_pending && cyc_stb && instr_done));

  p_chain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_xfer && nxt_xfer) || (done_lbi && nxt_lbi)) |-> !irq_ack);

  p_chain_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_hold |-> !irq_ack);

  p_ack_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (stk_pc == PC_W'($past(pc_in) + 1'b1) && stk_skip == $past(skip_pend)));

  p_ack_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !int_en);

  p_core_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !irq_ack) |=> (stk_pc == $past(push_pc) && !stk_skip));

endmodule

bind irq_vector_unit irq_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_stb     (cyc_stb),
  .irq_pin     (irq_pin),
  .instr_done  (instr_done),
  .done_xfer   (done_xfer),
  .done_lbi    (done_lbi),
  .nxt_xfer    (nxt_xfer),
  .nxt_lbi     (nxt_lbi),
  .pc_in       (pc_in),
  .skip_pend   (skip_pend),
  .push_req    (push_req),
  .push_pc     (push_pc),
  .irq_ack     (irq_ack),
  .int_en      (int_en),
  .irq_pending (irq_pending),
  .stk_pc      (stk_pc),
  .stk_skip    (stk_skip),
  .qual_evt    (qual_evt),
  .chain_hold  (chain_hold)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 0, irq_pin = 0, ien_set = 0, ien_clr = 0;
  logic       instr_done = 0, done_xfer = 0, done_lbi = 0, nxt_xfer = 0, nxt_lbi = 0;
  logic [9:0] pc_in = '0, push_pc = '0;
  logic       skip_pend = 0, push_req = 0, pop_req = 0;
  logic       irq_ack, int_en, irq_pending, stk_skip;
  logic [9:0] vec_pc, stk_pc;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference model state
  int m_armed, m_low, m_req, m_en;
  int m_pc[$];
  int m_sk[$];

  always #10 clk = ~clk;

  irq_vector_unit dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_pin(irq_pin),
    .ien_set(ien_set), .ien_clr(ien_clr), .instr_done(instr_done),
    .done_xfer(done_xfer), .done_lbi(done_lbi), .nxt_xfer(nxt_xfer), .nxt_lbi(nxt_lbi),
    .pc_in(pc_in), .skip_pend(skip_pend), .push_req(push_req), .push_pc(push_pc),
    .pop_req(pop_req), .irq_ack(irq_ack), .vec_pc(vec_pc), .int_en(int_en),
    .irq_pending(irq_pending), .stk_pc(stk_pc), .stk_skip(stk_skip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ack();
    int blk;
    blk = (done_xfer && nxt_xfer) || (done_lbi && nxt_lbi);
    return (cyc_stb && instr_done && m_en && m_req && !blk) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_armed = 0; m_low = 0; m_req = 0; m_en = 0;
    m_pc = '{0, 0, 0};
    m_sk = '{0, 0, 0};
  endtask

  // Compare every output against the model, then advance the model one clock.
  task automatic step();
    int a;
    int setq;
    #2;
    a = exp_ack();
    chk("R4 irq_ack", irq_ack, a);
    chk("R8 int_en", int_en, m_en);
    chk("R3 irq_pending", irq_pending, m_req);
    chk("R6 stk_pc", stk_pc, m_pc[0]);
    chk("R9 stk_skip", stk_skip, m_sk[0]);
    chk("R7 vec_pc", vec_pc, 'h0FF);
    setq = 0;
    if (cyc_stb) begin
      if (irq_pin) begin
        m_armed = 1; m_low = 0;
      end else if (m_req || !m_armed) begin
        m_armed = 0; m_low = 0;
      end else begin
        m_low++;
        if (m_low >= 2) begin
          setq = 1; m_armed = 0; m_low = 0;
        end
      end
    end
    if (setq) m_req = 1;
    else if (a) m_req = 0;
    if (a || ien_clr) m_en = 0;
    else if (ien_set) m_en = 1;
    if (a) begin
      m_pc.push_front((pc_in + 1) % 1024); m_sk.push_front(skip_pend);
      void'(m_pc.pop_back()); void'(m_sk.pop_back());
    end else if (push_req) begin
      m_pc.push_front(push_pc); m_sk.push_front(0);
      void'(m_pc.pop_back()); void'(m_sk.pop_back());
    end else if (pop_req) begin
      void'(m_pc.pop_front()); void'(m_sk.pop_front());
      m_pc.push_back(m_pc[1]); m_sk.push_back(m_sk[1]);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc_stb = 0; irq_pin = irq_pin; ien_set = 0; ien_clr = 0;
    instr_done = 0; done_xfer = 0; done_lbi = 0; nxt_xfer = 0; nxt_lbi = 0;
    skip_pend = 0; push_req = 0; pop_req = 0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk("R1 int_en", int_en, 0);
    chk("R1 irq_pending", irq_pending, 0);
    chk("R1 irq_ack", irq_ack, 0);
    chk("R1 stk_pc", stk_pc, 0);
    @(negedge clk);

    idle(); ien_set = 1; step(); idle();
    chk("R8 enable set", int_en, 1);

    // R2: short low pulse and unstrobed low samples give no request
    irq_pin = 1; cyc_stb = 1; step(); step();
    irq_pin = 0; cyc_stb = 1; step();
    cyc_stb = 0; step(); step();
    irq_pin = 1; cyc_stb = 1; step();
    chk("R2 short pulse ignored", irq_pending, 0);
    irq_pin = 0; step();
    chk("R2 one low sample", irq_pending, 0);
    step();
    chk("R2 two low samples qualify", irq_pending, 1);

    // R5: chain of transfers holds acknowledgement
    instr_done = 1; done_xfer = 1; nxt_xfer = 1; pc_in = 10'h3FF; skip_pend = 1;
    #1 chk("R5 chain held", irq_ack, 0);
    step();
    done_xfer = 0; nxt_xfer = 0; done_lbi = 1; nxt_lbi = 1;
    #1 chk("R5 lbi chain held", irq_ack, 0);
    step();
    nxt_lbi = 0;
    #1 chk("R4 ack at chain end", irq_ack, 1);
    step(); idle(); cyc_stb = 1;
    chk("R6 wrapped return addr", stk_pc, 10'h000);
    chk("R6 skip saved", stk_skip, 1);
    chk("R8 ack clears enable", int_en, 0);
    chk("R3 pending cleared", irq_pending, 0);

    // R4: request forms while disabled but is not acknowledged
    irq_pin = 1; step(); irq_pin = 0; step(); step();
    instr_done = 1; #1 chk("R4 no ack while disabled", irq_ack, 0);
    chk("R4 request held", irq_pending, 1);
    step(); idle();

    // R9: core calls and returns
    push_req = 1; push_pc = 10'h123; step();
    push_pc = 10'h045; step(); idle();
    chk("R9 push top", stk_pc, 10'h045);
    pop_req = 1; step(); idle();
    chk("R9 pop returns", stk_pc, 10'h123);
    pop_req = 1; step(); idle();
    chk("R9 skip restored", stk_skip, 1);

    // R10/R8: ack overrides core stack requests and a simultaneous enable set
    ien_set = 1; step(); idle();
    cyc_stb = 1; instr_done = 1; pc_in = 10'h100; push_req = 1; push_pc = 10'h2AA;
    pop_req = 1; ien_set = 1;
    #1 chk("R4 ack after re-arm", irq_ack, 1);
    step(); idle();
    chk("R10 ack push wins", stk_pc, 10'h101);
    chk("R8 clear beats set", int_en, 0);
    pop_req = 1; step(); idle();
    chk("R10 core push dropped", stk_pc, 10'h000);
    chk("R10 skip under ack", stk_skip, 1);

    // Mixed stimulus compared against the model on every clock
    for (int i = 0; i < 3000; i++) begin
      cyc_stb    = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 5) == 0) irq_pin = ~irq_pin;
      ien_set    = ($urandom_range(0, 9) == 0);
      ien_clr    = ($urandom_range(0, 29) == 0);
      instr_done = ($urandom_range(0, 9) < 6);
      done_xfer  = ($urandom_range(0, 3) == 0);
      done_lbi   = ($urandom_range(0, 3) == 0);
      nxt_xfer   = ($urandom_range(0, 2) == 0);
      nxt_lbi    = ($urandom_range(0, 2) == 0);
      pc_in      = 10'($urandom);
      skip_pend  = ($urandom_range(0, 1) == 1);
      push_req   = ($urandom_range(0, 19) == 0);
      push_pc    = 10'($urandom);
      pop_req    = ($urandom_range(0, 9) == 0);
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule